// File: doc/BRIEF.md
# DDS Phase Accumulator with Selectable Clear

This block is the numeric heart of a direct digital synthesizer. On every rising clock edge a wide phase accumulator adds one of two tuning words. The top bits of the accumulator, plus one of two phase offsets, form the phase output that a downstream phase-to-amplitude stage consumes. That stage and the converter behind it sit outside this block. A select line chooses each tuning word, and another chooses each offset. Each choice takes hold at the next accumulator update.

The block also owns the clear logic for the synthesizer. A source-select input decides whether a hardware clear pin or a software clear bit controls the clear. The source that is not selected is ignored.

- Assertion of the chosen clear is asynchronous. It empties the accumulator at once and drives the phase output to zero, the code that a sine stage maps to midscale.
- Release of the clear is sampled on a falling clock edge.
- After release, valid output returns only after a fixed count of rising edges.

The tuning words and offsets are plain inputs, and the clear never alters them. A synchronous active-low system reset (`rst_n`) brings the block up in the cleared state.

Top module: `dds_phase_core`

## Requirements
- R1: When `clr_src_i` is 0, `clr_bit_i` alone controls the clear, and `clr_pin_i` has no effect on `valid_o` or `phase_o`.
- R2: When `clr_src_i` is 1, `clr_pin_i` alone controls the clear, and `clr_bit_i` has no effect on `valid_o` or `phase_o`.
- R3: When the selected clear source goes to 1, `valid_o` falls to 0 and `phase_o` becomes 0 without waiting for a clock edge.
- R4: A release of the clear is seen only at a falling clock edge. If the release arrives after a falling edge, the following rising edge still treats the block as cleared.
- R5: While the clear is held, the accumulator stays at 0, `valid_o` is 0 and `phase_o` is 0. After release, accumulation restarts from 0.
- R6: `valid_o` becomes 1 right after the LATENCY-th rising edge (default 7) following the falling edge that samples the release. By then the accumulator holds LATENCY times the tuning word.
- R7: On each rising edge outside clear, the accumulator adds the selected tuning word modulo 2^ACC_W. `step_sel_i` = 0 picks `step0_i` and 1 picks `step1_i`.
- R8: While `valid_o` is 1, `phase_o` equals accumulator bits [ACC_W-1 : ACC_W-PH_W] plus the registered offset, modulo 2^PH_W. While `valid_o` is 0, `phase_o` is 0.
- R9: A change of `step_sel_i` or `offs_sel_i` takes effect at the next rising edge. `offs_sel_i` = 0 picks `offs0_i` and 1 picks `offs1_i`.
- R10: With `rst_n` low, the block holds the cleared state: accumulator 0, offset register 0, `valid_o` 0 and the latency count restarted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; accumulator updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low system reset |
| step0_i | input | ACC_W | Tuning word 0 |
| step1_i | input | ACC_W | Tuning word 1 |
| step_sel_i | input | 1 | Tuning word select (0 = word 0, 1 = word 1) |
| offs0_i | input | PH_W | Phase offset 0 |
| offs1_i | input | PH_W | Phase offset 1 |
| offs_sel_i | input | 1 | Phase offset select (0 = offset 0, 1 = offset 1) |
| clr_pin_i | input | 1 | Hardware clear request |
| clr_bit_i | input | 1 | Software clear request |
| clr_src_i | input | 1 | Clear source select (0 = software bit, 1 = hardware pin) |
| phase_o | output | PH_W | Phase word for the amplitude stage |
| valid_o | output | 1 | Phase output is live |

## Verification
The bench builds the block with ACC_W = 10 and PH_W = 4 and keeps LATENCY at 7. With a 10-bit accumulator, every tuning word can be driven once in a single sweep of about a thousand cycles. Many of those sweep steps wrap the accumulator, so the modulo arithmetic is exercised everywhere rather than at one carry. A 4-bit phase output means each offset value and its overflow on addition recur many times during the sweep. Keeping the full latency of seven lets the bench count the exact release-to-valid window. All eight combinations of source select, pin and bit are exercised, along with a release that arrives just after a falling edge.

// File: rtl/dds_core_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and the clear-source encoding for the DDS phase core.
// Assumes: consumers import it before use.
package dds_core_pkg;

    parameter int unsigned DEF_ACC_W   = 28;
    parameter int unsigned DEF_PH_W    = 12;
    parameter int unsigned DEF_LATENCY = 7;

    // Which request governs the clear.
    typedef enum logic {
        SRC_SOFT_BIT = 1'b0,
        SRC_HW_PIN   = 1'b1
    } clr_src_e;

endpackage

// File: rtl/dds_clr_ctl.sv
`timescale 1ns/1ps
// Module: dds_clr_ctl
// Picks the governing clear request and produces the hold signal.
// The hold is set asynchronously as soon as the selected request rises.
// It is released only at a falling clock edge that sees the request low.
// Assumes: rst_n is synchronous active-low; the request is quasi-static
// relative to clk (a glitch on the selected request forces a clear).
module dds_clr_ctl
    import dds_core_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_src_i,
    input  logic clr_pin_i,
    input  logic clr_bit_i,
    output logic clr_req_o,
    output logic hold_o
);

    clr_src_e src;
    logic     hold_q;

    // Decode the source select into its named encoding.
    assign src = clr_src_e'(clr_src_i);

    // Route only the governing request; the other is ignored.
    always_comb begin
        if (src == SRC_HW_PIN) clr_req_o = clr_pin_i;
        else                   clr_req_o = clr_bit_i;
    end

    // Asynchronous set on request; release sampled on the falling edge.
    always_ff @(negedge clk or posedge clr_req_o) begin
        if (clr_req_o)   hold_q <= 1'b1;
        else if (!rst_n) hold_q <= 1'b1;
        else             hold_q <= 1'b0;
    end

    assign hold_o = hold_q;

endmodule

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
// Module: dds_phase_acc
// Phase accumulator plus the registered phase offset.
// The selected tuning word is added modulo 2^ACC_W on each rising edge.
// The selected offset is registered on the same edge, so both selections
// change together at one update.
// Assumes: hold_i clears the accumulator asynchronously; rst_n is synchronous.
module dds_phase_acc #(
    parameter int unsigned ACC_W = 28,
    parameter int unsigned PH_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic [ACC_W-1:0] step0_i,
    input  logic [ACC_W-1:0] step1_i,
    input  logic             step_sel_i,
    input  logic [PH_W-1:0]  offs0_i,
    input  logic [PH_W-1:0]  offs1_i,
    input  logic             offs_sel_i,
    output logic [ACC_W-1:0] acc_o,
    output logic [PH_W-1:0]  off_o
);

    logic [ACC_W-1:0] step_w;
    logic [ACC_W-1:0] acc_q;
    logic [PH_W-1:0]  off_q;

    // Select the tuning word that applies at the coming edge.
    assign step_w = step_sel_i ? step1_i : step0_i;

    // Accumulate; cleared immediately while hold is high.
    always_ff @(posedge clk or posedge hold_i) begin
        if (hold_i)      acc_q <= '0;
        else if (!rst_n) acc_q <= '0;
        else             acc_q <= acc_q + step_w;
    end

    // Register the chosen offset; the clear leaves it untouched.
    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= '0;
        else        off_q <= offs_sel_i ? offs1_i : offs0_i;
    end

    assign acc_o = acc_q;
    assign off_o = off_q;

endmodule

// File: rtl/dds_resume_timer.sv
`timescale 1ns/1ps
// Module: dds_resume_timer
// Counts rising edges since the hold was released and flags valid output
// once LATENCY edges have passed. The count saturates at LATENCY.
// Assumes: hold_i clears the count asynchronously; LATENCY >= 1.
module dds_resume_timer #(
    parameter int unsigned LATENCY = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic valid_o
);

    localparam int unsigned CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] DONE = CW'(LATENCY);

    logic [CW-1:0] cnt_q;

    // Count edges since release, stopping at the latency value.
    always_ff @(posedge clk or posedge hold_i) begin
        if (hold_i)             cnt_q <= '0;
        else if (!rst_n)        cnt_q <= '0;
        else if (cnt_q != DONE) cnt_q <= cnt_q + CW'(1);
    end

    assign valid_o = (cnt_q == DONE);

endmodule

// File: rtl/dds_phase_map.sv
`timescale 1ns/1ps
// Module: dds_phase_map
// Forms the output phase from the top accumulator bits plus the offset.
// Forces the idle code (zero) while the output is not valid.
// Assumes: PH_W <= ACC_W.
module dds_phase_map #(
    parameter int unsigned ACC_W = 28,
    parameter int unsigned PH_W  = 12
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [PH_W-1:0]  off_i,
    input  logic             valid_i,
    output logic [PH_W-1:0]  phase_o
);

    logic [PH_W-1:0] top_w;

    // Take the accumulator's top bits; the slice depends on the width relation.
    generate
        if (PH_W == ACC_W) begin : g_full
            assign top_w = acc_i;
        end else if (PH_W < ACC_W) begin : g_slice
            assign top_w = acc_i[ACC_W-1 -: PH_W];
        end else begin : g_bad
            $error("dds_phase_map: PH_W must not exceed ACC_W");
            assign top_w = '0;
        end
    endgenerate

    // Add the offset, or park at the idle code.
    assign phase_o = valid_i ? (top_w + off_i) : '0;

endmodule

// File: rtl/dds_phase_core.sv
`timescale 1ns/1ps
// Module: dds_phase_core (top)
// DDS phase core: clear control, accumulator, resume timer and phase map.
// Assumes: clk is the sample clock; rst_n is synchronous active-low.
module dds_phase_core #(
    parameter int unsigned ACC_W   = dds_core_pkg::DEF_ACC_W,
    parameter int unsigned PH_W    = dds_core_pkg::DEF_PH_W,
    parameter int unsigned LATENCY = dds_core_pkg::DEF_LATENCY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step0_i,
    input  logic [ACC_W-1:0] step1_i,
    input  logic             step_sel_i,
    input  logic [PH_W-1:0]  offs0_i,
    input  logic [PH_W-1:0]  offs1_i,
    input  logic             offs_sel_i,
    input  logic             clr_pin_i,
    input  logic             clr_bit_i,
    input  logic             clr_src_i,
    output logic [PH_W-1:0]  phase_o,
    output logic             valid_o
);

    logic             clr_req;
    logic             hold_w;
    logic [ACC_W-1:0] acc_w;
    logic [PH_W-1:0]  off_w;

    dds_clr_ctl u_clr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_src_i (clr_src_i),
        .clr_pin_i (clr_pin_i),
        .clr_bit_i (clr_bit_i),
        .clr_req_o (clr_req),
        .hold_o    (hold_w)
    );

    dds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (hold_w),
        .step0_i    (step0_i),
        .step1_i    (step1_i),
        .step_sel_i (step_sel_i),
        .offs0_i    (offs0_i),
        .offs1_i    (offs1_i),
        .offs_sel_i (offs_sel_i),
        .acc_o      (acc_w),
        .off_o      (off_w)
    );

    dds_resume_timer #(.LATENCY(LATENCY)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (hold_w),
        .valid_o (valid_o)
    );

    dds_phase_map #(.ACC_W(ACC_W), .PH_W(PH_W)) u_map (
        .acc_i   (acc_w),
        .off_i   (off_w),
        .valid_i (valid_o),
        .phase_o (phase_o)
    );

endmodule

// File: rtl/dds_phase_core_chk.sv
`timescale 1ns/1ps
// Module: dds_phase_core_chk
// Property checker bound into dds_phase_core. It observes the ports and
// the signals passed between the submodules.
// Assumes: the bind below supplies the top's internal nets.
module dds_phase_core_chk #(
    parameter int unsigned ACC_W   = 28,
    parameter int unsigned PH_W    = 12,
    parameter int unsigned LATENCY = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ACC_W-1:0] step0_i,
    input logic [ACC_W-1:0] step1_i,
    input logic             step_sel_i,
    input logic [PH_W-1:0]  offs0_i,
    input logic [PH_W-1:0]  offs1_i,
    input logic             offs_sel_i,
    input logic             clr_pin_i,
    input logic             clr_bit_i,
    input logic             clr_src_i,
    input logic [PH_W-1:0]  phase_o,
    input logic             valid_o,
    input logic             hold_w,
    input logic [ACC_W-1:0] acc_w,
    input logic [PH_W-1:0]  off_w
);

    localparam int unsigned CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] DONE = CW'(LATENCY);

    logic [CW-1:0] run_cnt;

    // Independent count of edges seen with the hold low.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_w)  run_cnt <= '0;
        else if (run_cnt != DONE) run_cnt <= run_cnt + CW'(1);
    end

    assert_bit_governs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_src_i && clr_bit_i) |-> hold_w);

    assert_pin_governs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_src_i && clr_pin_i) |-> hold_w);

    assert_held_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_w |-> (!valid_o && phase_o == '0 && acc_w == '0));

    assert_first_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold_w) |-> !valid_o);

    assert_resume_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> (run_cnt == DONE));

    assert_acc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(hold_w) && !hold_w) |->
        (acc_w == $past(acc_w) + $past(step_sel_i ? step1_i : step0_i)));

    assert_phase_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (phase_o == PH_W'(acc_w[ACC_W-1 -: PH_W] + off_w)));

    assert_offset_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (off_w == $past(offs_sel_i ? offs1_i : offs0_i)));

endmodule

bind dds_phase_core dds_phase_core_chk #(
    .ACC_W(ACC_W), .PH_W(PH_W), .LATENCY(LATENCY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step0_i    (step0_i),
    .step1_i    (step1_i),
    .step_sel_i (step_sel_i),
    .offs0_i    (offs0_i),
    .offs1_i    (offs1_i),
    .offs_sel_i (offs_sel_i),
    .clr_pin_i  (clr_pin_i),
    .clr_bit_i  (clr_bit_i),
    .clr_src_i  (clr_src_i),
    .phase_o    (phase_o),
    .valid_o    (valid_o),
    .hold_w     (hold_w),
    .acc_w      (acc_w),
    .off_w      (off_w)
);

// File: tb/dds_phase_core_test.sv
`timescale 1ns/1ps
// Bench: small configuration, full tuning-word sweep, every clear combination.
// The expected phase comes from an arithmetic model written from the requirements.
module dds_phase_core_test;

    localparam int unsigned ACC_W   = 10;
    localparam int unsigned PH_W    = 4;
    localparam int unsigned LATENCY = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [ACC_W-1:0] step0 = '0, step1 = '0;
    logic             step_sel = 1'b0;
    logic [PH_W-1:0]  offs0 = '0, offs1 = '0;
    logic             offs_sel = 1'b0;
    logic             clr_pin = 1'b0, clr_bit = 1'b0, clr_src = 1'b0;
    logic [PH_W-1:0]  phase;
    logic             valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state
    logic [ACC_W-1:0] m_acc = '0;
    logic [PH_W-1:0]  m_off = '0;
    int               m_cnt = 0;
    bit               held_at_neg = 1'b1;

    dds_phase_core #(.ACC_W(ACC_W), .PH_W(PH_W), .LATENCY(LATENCY)) uut (
        .clk(clk), .rst_n(rst_n),
        .step0_i(step0), .step1_i(step1), .step_sel_i(step_sel),
        .offs0_i(offs0), .offs1_i(offs1), .offs_sel_i(offs_sel),
        .clr_pin_i(clr_pin), .clr_bit_i(clr_bit), .clr_src_i(clr_src),
        .phase_o(phase), .valid_o(valid)
    );

    always #2.5 clk = ~clk;

    function automatic bit req_active();
        return clr_src ? clr_pin : clr_bit;
    endfunction

    // Record the falling-edge view of the clear (release is seen here).
    always @(negedge clk) held_at_neg = req_active() || !rst_n;

    task automatic compare(input string tag, input bit exp_v, input logic [PH_W-1:0] exp_p);
        checks++;
        if (valid !== exp_v || phase !== exp_p) begin
            fails++;
            $display("FAIL %s: valid=%0b phase=%0h expected valid=%0b phase=%0h",
                     tag, valid, phase, exp_v, exp_p);
        end
    endtask

    task automatic check_model(input string tag);
        bit ev;
        logic [PH_W-1:0] ep;
        ev = (m_cnt == LATENCY);
        ep = ev ? PH_W'(m_acc[ACC_W-1 -: PH_W] + m_off) : '0;
        compare(tag, ev, ep);
    endtask

    // One rising edge: update the model, then compare 1 ns later.
    task automatic tick(input string tag);
        @(posedge clk);
        if (held_at_neg || req_active()) begin
            m_acc = '0;
            m_cnt = 0;
        end else begin
            m_acc = m_acc + (step_sel ? step1 : step0);
            if (m_cnt < LATENCY) m_cnt++;
        end
        if (!rst_n) m_off = '0;
        else        m_off = offs_sel ? offs1 : offs0;
        #1;
        check_model(tag);
    endtask

    initial begin
        // R10: system reset holds the cleared state
        step0 = 10'h0A5; step1 = 10'h31C; offs0 = 4'h3; offs1 = 4'hC;
        for (int i = 0; i < 4; i++) tick("R10");
        rst_n = 1'b1;

        // R6: valid exactly on the LATENCY-th edge after release
        for (int k = 1; k <= LATENCY; k++) begin
            tick("R6");
            checks++;
            if (valid !== (k == LATENCY)) begin
                fails++;
                $display("FAIL R6: edge %0d valid=%0b expected %0b", k, valid, (k == LATENCY));
            end
        end

        // R7/R8: sweep every tuning word and offset, alternating selections
        for (int i = 0; i < (1 << ACC_W); i++) begin
            step0 = ACC_W'(i); step1 = ~ACC_W'(i);
            offs0 = PH_W'(i); offs1 = PH_W'(i * 7 + 3);
            step_sel = i[1]; offs_sel = i[2];
            tick("R7");
        end

        // R9: selections flip every edge with distinct words
        step0 = 10'h011; step1 = 10'h2F3; offs0 = 4'h1; offs1 = 4'h9;
        for (int i = 0; i < 24; i++) begin
            step_sel = ~step_sel;
            if (i % 3 == 0) offs_sel = ~offs_sel;
            tick("R9");
        end

        // R1: software bit governs; the pin is ignored
        clr_src = 1'b0; clr_pin = 1'b1;
        for (int i = 0; i < 5; i++) tick("R1");
        clr_bit = 1'b1;
        #0.5;
        compare("R3", 1'b0, '0);
        for (int i = 0; i < 4; i++) tick("R5");
        clr_bit = 1'b0;
        for (int i = 0; i < 12; i++) tick("R5");
        clr_pin = 1'b0;

        // R2: hardware pin governs; the bit is ignored
        clr_src = 1'b1; clr_bit = 1'b1;
        for (int i = 0; i < 5; i++) tick("R2");
        clr_pin = 1'b1;
        #0.5;
        compare("R3", 1'b0, '0);
        for (int i = 0; i < 4; i++) tick("R2");
        clr_pin = 1'b0;
        for (int i = 0; i < 12; i++) tick("R2");
        clr_bit = 1'b0;

        // All eight source/pin/bit combinations
        for (int c = 0; c < 8; c++) begin
            clr_src = c[2]; clr_pin = c[1]; clr_bit = c[0];
            for (int i = 0; i < 3; i++) tick(clr_src ? "R2" : "R1");
            clr_pin = 1'b0; clr_bit = 1'b0;
            for (int i = 0; i < 9; i++) tick(clr_src ? "R2" : "R1");
        end

        // R4: release arriving just after a falling edge is not yet seen
        clr_src = 1'b0; clr_bit = 1'b1;
        for (int i = 0; i < 3; i++) tick("R4");
        #2;
        clr_bit = 1'b0;
        tick("R4");
        checks++;
        if (valid !== 1'b0) begin
            fails++;
            $display("FAIL R4: valid=%0b expected 0", valid);
        end
        for (int i = 0; i < 10; i++) tick("R4");

        // R10: mid-run system reset clears the offset register and restarts
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) tick("R10");
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) tick("R10");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule